// File: doc/BRIEF.md
# Byte ALU with Chainable Status Flags

This block is a purely combinational 8-bit arithmetic/logic unit that computes a result and a full next-state status byte in the same cycle. It takes two operands, a 4-bit operation code and the current status byte. It returns the result, a write-enable that says whether the result should be stored, and the status byte the surrounding core latches. Multiply, branching and the register file sit outside the block. The status byte carries the condition bits that a branch unit would test.

The flags are built so that wider arithmetic runs one byte at a time. The carry-consuming subtract and compare only ever clear the zero flag and never set it. A 16- or 32-bit compare therefore reports equality over all bytes. Its carry and signed-test flags also rank the whole operand, not just the top byte.

Status bit positions: bit 7 interrupt enable (I), bit 6 bit-transfer flag (T), bit 5 half carry (H), bit 4 signed test (S), bit 3 overflow (V), bit 2 negative (N), bit 1 zero (Z), bit 0 carry (C).

Top module: `byte_alu`

## Requirements
- R1: Opcodes 0 (add) and 1 (add plus C) give result = a + b (+ C). C is set on carry out of bit 7, H on carry out of bit 3, and V on two's-complement overflow.
- R2: Opcodes 2 (subtract) and 3 (subtract minus C) give result = a − b (− C). C is set when a borrow is needed (unsigned a < b + carry-in), H on a borrow from bit 4 into bit 3, and V on signed overflow.
- R3: For opcodes 3 and 5, Z out is 1 only when the result is zero and Z in was 1; a zero result with Z in = 0 leaves Z at 0.
- R4: Opcodes 4 (compare) and 5 (compare minus C) produce the same flags as opcodes 2 and 3 and drive the write-enable low; every other opcode drives it high.
- R5: Opcodes 6 (AND), 7 (OR) and 8 (XOR) give the bitwise result, clear V and keep C and H from the status input.
- R6: Opcode 9 (increment) and opcode 10 (decrement) give a+1 / a−1 modulo 256 and keep C and H. V is set only for 0x7F→0x80 on increment and 0x80→0x7F on decrement.
- R7: Opcode 11 (shift left, 0 into bit 0) and opcode 12 (rotate left, old C into bit 0) put old bit 7 into C and old bit 3 into H, and set V = N xor C.
- R8: Opcode 13 (shift right, 0 into bit 7), opcode 14 (rotate right, old C into bit 7) and opcode 15 (arithmetic shift right, bit 7 kept) put old bit 0 into C, set V = N xor C and keep H.
- R9: For every opcode, N equals result bit 7 and S equals N xor V. For opcodes other than 3 and 5, Z is set exactly when the result is zero.
- R10: Bits I (7) and T (6) of the status output equal those of the status input for every opcode.
- R11: A compare on the lowest byte followed by three compare-minus-C steps, each fed the previous status output, gives Z = (A == B), C = (A < B unsigned) and S = (A < B signed) for 32-bit A and B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (0 to 15, see requirements) |
| a_i | input | 8 | First operand, also the operand of unary operations |
| b_i | input | 8 | Second operand |
| flags_i | input | 8 | Current status byte |
| result_o | output | 8 | Computed result (difference for compares) |
| wr_en_o | output | 1 | High when the result should be written back |
| flags_o | output | 8 | Next status byte |

## Verification
The checks assume that every input is driven to a known value whenever they are evaluated. While any input carries X or Z they stand down, which covers the time before the bench first applies a vector. The bench drives all four inputs together at one clock edge, and only with defined values. Every opcode is swept against all 256 values of the first operand, a spread of second operands and all four carry/zero input combinations. It then chains compares over 32-bit pairs that include equal, one-byte-different and sign-crossing cases.

// File: rtl/byte_alu_pkg.sv
// Package: shared opcode encoding and status-bit positions for the byte ALU.
// Assumes the status byte layout I,T,H,S,V,N,Z,C from bit 7 down to bit 0.
package byte_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_CMP = 4'd4,
        OP_CPC = 4'd5,
        OP_AND = 4'd6,
        OP_OR  = 4'd7,
        OP_XOR = 4'd8,
        OP_INC = 4'd9,
        OP_DEC = 4'd10,
        OP_LSL = 4'd11,
        OP_ROL = 4'd12,
        OP_LSR = 4'd13,
        OP_ROR = 4'd14,
        OP_ASR = 4'd15
    } alu_op_e;

    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_N = 2;
    localparam int FLG_V = 3;
    localparam int FLG_S = 4;
    localparam int FLG_H = 5;
    localparam int FLG_T = 6;
    localparam int FLG_I = 7;

endpackage

// File: rtl/alu_addsub.sv
// Module: add/subtract core shared by add, subtract, compare, increment and
// decrement. In subtract mode carry_in is a borrow-in and carry_o/half_o
// report borrows. Assumes WIDTH is even so the half point is WIDTH/2.
module alu_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             carry_in,
    input  logic             subtract,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o,
    output logic             half_o,
    output logic             ovf_o
);
    localparam int HALF = WIDTH / 2;

    logic [WIDTH-1:0] b_eff;
    logic             c_eff;
    logic [WIDTH:0]   full;
    logic [HALF:0]    low;

    // Invert the subtrahend and the borrow so one adder serves both modes.
    always_comb begin
        b_eff   = subtract ? ~b_i : b_i;
        c_eff   = subtract ? ~carry_in : carry_in;
        full    = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c_eff};
        low     = {1'b0, a_i[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]} + {{HALF{1'b0}}, c_eff};
        sum_o   = full[WIDTH-1:0];
        carry_o = full[WIDTH] ^ subtract;
        half_o  = low[HALF] ^ subtract;
        ovf_o   = (a_i[WIDTH-1] == b_eff[WIDTH-1]) && (full[WIDTH-1] != a_i[WIDTH-1]);
    end

endmodule

// File: rtl/alu_shift.sv
// Module: single-position shifter and rotator. Left variants fill bit 0 with
// zero or the carry; right variants fill the top bit with zero, the carry or
// the old top bit. Assumes only shift opcodes are meaningful here.
module alu_shift #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic             carry_in,
    input  logic [3:0]       op_i,
    output logic [WIDTH-1:0] res_o,
    output logic             carry_o
);
    import byte_alu_pkg::*;

    // Pick the shift direction and the bit shifted in.
    always_comb begin
        unique case (alu_op_e'(op_i))
            OP_LSL:  begin res_o = {a_i[WIDTH-2:0], 1'b0};          carry_o = a_i[WIDTH-1]; end
            OP_ROL:  begin res_o = {a_i[WIDTH-2:0], carry_in};      carry_o = a_i[WIDTH-1]; end
            OP_LSR:  begin res_o = {1'b0, a_i[WIDTH-1:1]};          carry_o = a_i[0]; end
            OP_ROR:  begin res_o = {carry_in, a_i[WIDTH-1:1]};      carry_o = a_i[0]; end
            OP_ASR:  begin res_o = {a_i[WIDTH-1], a_i[WIDTH-1:1]};  carry_o = a_i[0]; end
            default: begin res_o = a_i;                             carry_o = carry_in; end
        endcase
    end

endmodule

// File: rtl/alu_logic.sv
// Module: bitwise AND/OR/XOR unit. Assumes only logic opcodes are meaningful.
module alu_logic #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [3:0]       op_i,
    output logic [WIDTH-1:0] res_o
);
    import byte_alu_pkg::*;

    // Select the bitwise function.
    always_comb begin
        unique case (alu_op_e'(op_i))
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            default: res_o = a_i;
        endcase
    end

endmodule

// File: rtl/byte_alu.sv
// Module: top of the combinational byte ALU. Routes the opcode to the
// add/subtract, shift or logic unit and assembles the next status byte.
// Subtract-with-carry and compare-with-carry only ever clear Z, so bytes
// chain into wider operations. Assumes the caller latches flags_o.
module byte_alu #(
    parameter int WIDTH = 8
) (
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [7:0]       flags_i,
    output logic [WIDTH-1:0] result_o,
    output logic             wr_en_o,
    output logic [7:0]       flags_o
);
    import byte_alu_pkg::*;

    localparam int HALF = WIDTH / 2;
    localparam int MSB  = WIDTH - 1;

    alu_op_e          op;
    logic [WIDTH-1:0] as_b;
    logic             as_cin;
    logic             as_sub;
    logic [WIDTH-1:0] as_sum;
    logic             as_c;
    logic             as_h;
    logic             as_v;
    logic [WIDTH-1:0] sh_res;
    logic             sh_c;
    logic [WIDTH-1:0] lg_res;
    logic             n_f;
    logic             v_f;
    logic             z_f;
    logic             c_f;
    logic             h_f;
    logic             flags_unused;

    assign op           = alu_op_e'(op_i);
    assign flags_unused = ^flags_i[FLG_S:FLG_N];

    // Choose the adder's second operand, carry-in and direction per opcode.
    always_comb begin
        as_b   = b_i;
        as_cin = 1'b0;
        as_sub = 1'b0;
        unique case (op)
            OP_ADC:                 as_cin = flags_i[FLG_C];
            OP_SUB, OP_CMP:         as_sub = 1'b1;
            OP_SBC, OP_CPC: begin   as_sub = 1'b1; as_cin = flags_i[FLG_C]; end
            OP_INC: begin           as_b = '0; as_cin = 1'b1; end
            OP_DEC: begin           as_b = '0; as_cin = 1'b1; as_sub = 1'b1; end
            default: ;
        endcase
    end

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_i      (a_i),
        .b_i      (as_b),
        .carry_in (as_cin),
        .subtract (as_sub),
        .sum_o    (as_sum),
        .carry_o  (as_c),
        .half_o   (as_h),
        .ovf_o    (as_v)
    );

    alu_shift #(.WIDTH(WIDTH)) u_shift (
        .a_i      (a_i),
        .carry_in (flags_i[FLG_C]),
        .op_i     (op_i),
        .res_o    (sh_res),
        .carry_o  (sh_c)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a_i   (a_i),
        .b_i   (b_i),
        .op_i  (op_i),
        .res_o (lg_res)
    );

    // Select the result, write-enable and the C/H/V sources per opcode class.
    always_comb begin
        result_o = as_sum;
        wr_en_o  = 1'b1;
        c_f      = as_c;
        h_f      = as_h;
        v_f      = as_v;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: ;
            OP_CMP, OP_CPC: wr_en_o = 1'b0;
            OP_AND, OP_OR, OP_XOR: begin
                result_o = lg_res;
                c_f      = flags_i[FLG_C];
                h_f      = flags_i[FLG_H];
                v_f      = 1'b0;
            end
            OP_INC, OP_DEC: begin
                c_f = flags_i[FLG_C];
                h_f = flags_i[FLG_H];
            end
            OP_LSL, OP_ROL: begin
                result_o = sh_res;
                c_f      = sh_c;
                h_f      = a_i[HALF-1];
                v_f      = sh_res[MSB] ^ sh_c;
            end
            default: begin
                result_o = sh_res;
                c_f      = sh_c;
                h_f      = flags_i[FLG_H];
                v_f      = sh_res[MSB] ^ sh_c;
            end
        endcase
    end

    // Derive N and Z, with Z only cleared by the carry-chaining subtracts.
    always_comb begin
        n_f = result_o[MSB];
        if (op == OP_SBC || op == OP_CPC)
            z_f = (result_o == '0) && flags_i[FLG_Z];
        else
            z_f = (result_o == '0);
    end

    // Pack the next status byte; I and T are passed through.
    always_comb begin
        flags_o        = flags_i;
        flags_o[FLG_H] = h_f;
        flags_o[FLG_S] = n_f ^ v_f;
        flags_o[FLG_V] = v_f;
        flags_o[FLG_N] = n_f;
        flags_o[FLG_Z] = z_f;
        flags_o[FLG_C] = c_f;
    end

endmodule

// File: rtl/byte_alu_checker.sv
// Module: property checker for byte_alu, attached with bind. The block has no
// clock, so the rules are immediate assertions evaluated whenever the ports
// change, gated off while any input is unknown.
module byte_alu_checker #(
    parameter int WIDTH = 8
) (
    input logic [3:0]       op_i,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [7:0]       flags_i,
    input logic [WIDTH-1:0] result_o,
    input logic             wr_en_o,
    input logic [7:0]       flags_o
);
    import byte_alu_pkg::*;

    logic known;
    assign known = !$isunknown({op_i, a_i, b_i, flags_i});

    // Check the port-level flag rules for the current input vector.
    always @* begin
        if (known) begin
            assert_sign_rule_R9: assert (flags_o[FLG_S] == (flags_o[FLG_N] ^ flags_o[FLG_V]));
            assert_neg_msb_R9: assert (flags_o[FLG_N] == result_o[WIDTH-1]);
            assert_pass_it_R10: assert (flags_o[7:6] == flags_i[7:6]);
            assert_cmp_no_write_R4: assert (wr_en_o == !(op_i == OP_CMP || op_i == OP_CPC));
            if ((op_i == OP_SBC || op_i == OP_CPC) && !flags_i[FLG_Z])
                assert_chain_z_clear_R3: assert (!flags_o[FLG_Z]);
            if (flags_o[FLG_Z])
                assert_zero_means_zero_R9: assert (result_o == '0);
            if (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR)
                assert_logic_flags_R5: assert (!flags_o[FLG_V] && flags_o[FLG_C] == flags_i[FLG_C]
                                               && flags_o[FLG_H] == flags_i[FLG_H]);
            if (op_i == OP_INC || op_i == OP_DEC)
                assert_step_keeps_ch_R6: assert (flags_o[FLG_C] == flags_i[FLG_C]
                                                 && flags_o[FLG_H] == flags_i[FLG_H]);
        end
    end

endmodule

bind byte_alu byte_alu_checker #(.WIDTH(WIDTH)) u_byte_alu_checker (
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .flags_i  (flags_i),
    .result_o (result_o),
    .wr_en_o  (wr_en_o),
    .flags_o  (flags_o)
);

// File: tb/byte_alu_test.sv
// Bench: sweeps every opcode over all first operands, a spread of second
// operands and all carry/zero inputs, comparing against an arithmetic model;
// then chains 32-bit compares.
module byte_alu_test;

    logic       clk = 1'b0;
    logic [3:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] fin;
    logic [7:0] res;
    logic       wr;
    logic [7:0] fout;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    byte_alu uut (
        .op_i     (op),
        .a_i      (a),
        .b_i      (b),
        .flags_i  (fin),
        .result_o (res),
        .wr_en_o  (wr),
        .flags_o  (fout)
    );

    // Expected {wr, result, flags} from plain integer arithmetic.
    function automatic logic [16:0] model(input int o, input int x, input int y, input logic [7:0] f);
        int r, sx, sy, sr, cin;
        logic c, h, v, z, n, w;
        cin = f[0];
        c = f[0]; h = f[5]; v = 1'b0; w = 1'b1;
        sx = (x > 127) ? x - 256 : x;
        sy = (y > 127) ? y - 256 : y;
        case (o)
            0, 1: begin
                if (o == 0) cin = 0;
                r  = x + y + cin;
                c  = r > 255;
                h  = ((x % 16) + (y % 16) + cin) > 15;
                sr = sx + sy + cin;
                v  = (sr > 127) || (sr < -128);
            end
            2, 3, 4, 5: begin
                if (o == 2 || o == 4) cin = 0;
                r  = x - y - cin;
                c  = r < 0;
                h  = ((x % 16) - (y % 16) - cin) < 0;
                sr = sx - sy - cin;
                v  = (sr > 127) || (sr < -128);
                w  = (o < 4);
            end
            6: r = x & y;
            7: r = x | y;
            8: r = x ^ y;
            9:  begin r = x + 1; v = (x == 127); end
            10: begin r = x - 1; v = (x == 128); end
            11, 12: begin
                r = x * 2 + ((o == 12) ? cin : 0);
                c = x >= 128; h = ((x / 8) % 2) == 1;
            end
            default: begin
                r = x / 2;
                if (o == 14) r = r + 128 * cin;
                if (o == 15 && x >= 128) r = r + 128;
                c = (x % 2) == 1;
            end
        endcase
        r = ((r % 256) + 256) % 256;
        n = r >= 128;
        if (o >= 11) v = n ^ c;
        z = (r == 0);
        if (o == 3 || o == 5) z = z && f[1];
        return {w, r[7:0], f[7], f[6], h, n ^ v, v, n, z, c};
    endfunction

    function automatic string tag(input int o);
        case (o)
            0, 1: return "R1";
            2, 3: return "R2";
            4, 5: return "R4";
            6, 7, 8: return "R5";
            9, 10: return "R6";
            11, 12: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s op=%0d a=%02h b=%02h fin=%02h actual=%05h expected=%05h",
                     req, op, a, b, fin, act, exp);
        end
    endtask

    task automatic apply(input int o, input int x, input int y, input logic [7:0] f);
        @(posedge clk);
        op = o[3:0]; a = x[7:0]; b = y[7:0]; fin = f;
        @(negedge clk);
    endtask

    // 32-bit chained compare; returns final flags.
    task automatic cmp32(input logic [31:0] ca, input logic [31:0] cb);
        logic [7:0] f;
        f = 8'hC0;
        for (int k = 0; k < 4; k++) begin
            apply((k == 0) ? 4 : 5, ca[8*k +: 8], cb[8*k +: 8], f);
            f = fout;
        end
        check("R11 Z", {16'd0, f[1]}, {16'd0, ca == cb});
        check("R11 C", {16'd0, f[0]}, {16'd0, ca < cb});
        check("R11 S", {16'd0, f[4]}, {16'd0, $signed(ca) < $signed(cb)});
        check("R10 chain I/T", {9'd0, f[7:6], 6'd0}, {9'd0, 2'b11, 6'd0});
    endtask

    initial begin
        op = '0; a = '0; b = '0; fin = '0;
        // Initial vector: add of zeros gives zero with Z set.
        apply(0, 0, 0, 8'h00);
        check("R1 initial add", {wr, res, fout}, {1'b1, 8'h00, 8'h02});
        // Explicit corner cases.
        apply(9, 8'h7F, 0, 8'h21);
        check("R6 inc 7F", {wr, res, fout}, {1'b1, 8'h80, 8'h2D});
        apply(10, 8'h80, 0, 8'h00);
        check("R6 dec 80", {wr, res, fout}, {1'b1, 8'h7F, 8'h18});
        apply(3, 8'h05, 8'h05, 8'h00);
        check("R3 zero diff with Z clear", {16'd0, fout[1]}, 17'd0);
        apply(3, 8'h05, 8'h04, 8'h03);
        check("R3 zero diff with borrow and Z set", {16'd0, fout[1]}, 17'd1);
        // Sweep.
        for (int o = 0; o < 16; o++)
            for (int x = 0; x < 256; x++)
                for (int j = 0; j < 16; j++) begin
                    int y = (j * 17 + x) % 256;
                    logic [7:0] f = {x[0], x[1], x[2], 2'b00, x[3], j[0], j[1]};
                    apply(o, x, y, f);
                    check(tag(o), {wr, res, fout}, model(o, x, y, f));
                    if (o == 3 || o == 5)
                        check("R3", {16'd0, fout[1]}, {16'd0, (res == 8'h00) && f[1]});
                    check("R9 S=N^V", {16'd0, fout[4]}, {16'd0, fout[2] ^ fout[3]});
                    check("R10 I/T", {9'd0, fout[7:6], 6'd0}, {9'd0, f[7:6], 6'd0});
                end
        // Chained 32-bit compares.
        cmp32(32'h1234_5678, 32'h1234_5678);
        cmp32(32'h1234_5678, 32'h1234_5679);
        cmp32(32'h0000_0100, 32'h0000_00FF);
        cmp32(32'h8000_0000, 32'h7FFF_FFFF);
        cmp32(32'hFFFF_FFFF, 32'h0000_0000);
        cmp32(32'h0100_0000, 32'h0000_0000);
        begin
            logic [31:0] s = 32'h1357_9BDF;
            for (int k = 0; k < 200; k++) begin
                logic [31:0] p;
                s = s * 32'd1664525 + 32'd1013904223;
                p = s;
                s = s * 32'd1664525 + 32'd1013904223;
                cmp32(p, (k % 3 == 0) ? p ^ (32'h1 << (k % 32)) : s);
            end
        end
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule